// File: doc/BRIEF.md
# Tag-History Phase Error Detector

This block sits between two timestamp taggers and a loop filter in a digital phase-locked loop. Each tag is a free-running counter sample that wraps at 2^TAG_BITS. The block keeps a separate circular history for the reference channel and for the output channel. It stores each incoming tag together with an unwrap offset, so that every channel reads as a phase that only ever increases.

Errors are formed by pairing the k-th reference entry with the k-th output entry. The pairing is by position in the sequence, not by the most recent arrival. A programmable phase shift is added to each error and the result is clamped. The shift is stepped toward its target once per error sample, but only while the loop reports lock.

The first time both histories hold data after reset, the block discards what it has collected and starts pairing afresh. To keep the offsets within their width, it rebases all of them whenever both paired entries have grown large.

Top module: `tagPhaseDetector`

## Requirements
- R1: After reset, errValid is low, both histories are empty, the applied shift is zero and the skip-first flag is set.
- R2: A tag with tagSrc=0 goes to the reference history and a tag with tagSrc=1 goes to the output history. Each channel has its own write index and pending count. No error is produced while either pending count is zero.
- R3: A stored entry's offset is the previous entry's offset plus 2^TAG_BITS when the previous entry's tag is strictly greater than the new tag. When the new tag is equal or greater, the previous offset is copied.
- R4: The first time both pending counts are nonzero with the skip-first flag set, all indices and counts clear and the last entry of each history is zeroed. The flag then clears and no error is produced.
- R5: In any later cycle without a tag where both counts are nonzero, the error is (refOffset+refTag+shift) − (outOffset+outTag) at the read index. errValid pulses on the following clock edge. The read index then advances and both counts drop by one, so reference and output entries pair in arrival order.
- R6: The error is clamped to the range −ERR_CLAMP to +ERR_CLAMP, with a default of 1,000,000.
- R7: When both offsets at the read index exceed 2^(TAG_BITS+2), 2^(TAG_BITS+1) is subtracted from every offset in both histories. Offsets are TAG_BITS+4 bits wide, so without this rebase errors go wrong after 16 wraps.
- R8: While locked is high, the applied shift moves one step toward shiftTarget after each error. The error always uses the value from before the step. While locked is low, the shift holds.
- R9: A tag always takes its cycle. An error computation that falls due in that cycle is deferred to the next cycle without a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tagValid | input | 1 | A tag is present this cycle |
| tagSrc | input | 1 | Channel of the tag: 0 reference, 1 output |
| tagValue | input | TAG_BITS | Tag value |
| locked | input | 1 | Loop lock indication; enables shift slewing |
| shiftTarget | input | SHIFT_W | Signed target for the applied phase shift |
| errValid | output | 1 | One-cycle strobe marking a new error |
| errValue | output | ERR_W | Signed, clamped phase error |

## Verification
The bench first checks that the tags collected before the first pairing are dropped without an error; a design that skipped this resynchronisation would emit a stale error right after reset. It sends tags that wrap on only one channel and tags equal to their predecessor; a wrong unwrap comparison would show up as an error off by 4,194,304. Bursts of reference tags followed by back-to-back output tags check that pairing follows arrival order and that an error falling due during a tag is deferred rather than lost. A long run of wrapping tags overflows the offsets of a design that never rebases, and the clamp and shift-slew vectors catch missing saturation, a shift applied too early, or a shift that drifts while unlocked.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_OUT = 1'b1
  } tagSrc_e;

  typedef struct packed {
    logic wrRef;
    logic wrOut;
    logic resync;
    logic emit;
  } ctrlStrobe_t;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/tpdHistory.sv
module tpdHistory #(
  parameter int TAG_BITS = 22,
  parameter int ADD_W    = 26,
  parameter int DEPTH    = 64,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [TAG_BITS-1:0] tagIn,
  input  logic                clrLast,
  input  logic                rebase,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [TAG_BITS-1:0] rdTag,
  output logic [ADD_W-1:0]    rdAdder
);

  localparam logic [ADD_W-1:0] TAG_SPAN    = {{(ADD_W-TAG_BITS-1){1'b0}}, 1'b1, {TAG_BITS{1'b0}}};
  localparam logic [ADD_W-1:0] REBASE_STEP = TAG_SPAN << 1;

  logic [TAG_BITS-1:0] tagMem [DEPTH];
  logic [ADD_W-1:0]    addMem [DEPTH];
  logic [IDX_W-1:0]    prevIdx;
  logic [ADD_W-1:0]    newAdder;

  // unwrap against the entry written just before this one
  assign prevIdx  = wrIdx - IDX_W'(1);
  assign newAdder = (tagMem[prevIdx] > tagIn) ? addMem[prevIdx] + TAG_SPAN
                                              : addMem[prevIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        tagMem[i] <= '0;
        addMem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clrLast && (i == DEPTH - 1)) begin
          tagMem[i] <= '0;
          addMem[i] <= '0;
        end else if (wrEn && (wrIdx == IDX_W'(i))) begin
          tagMem[i] <= tagIn;
          addMem[i] <= newAdder;
        end else if (rebase) begin
          addMem[i] <= addMem[i] - REBASE_STEP;
        end
      end
    end
  end

  assign rdTag   = tagMem[rdIdx];
  assign rdAdder = addMem[rdIdx];

endmodule

// File: rtl/tpdControl.sv
module tpdControl
  import tpd_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int SHIFT_W = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tagValid,
  input  logic                      tagSrc,
  input  logic                      locked,
  input  logic signed [SHIFT_W-1:0] shiftTarget,
  output ctrlStrobe_t               stb,
  output logic [IDX_W-1:0]          refWrIdx,
  output logic [IDX_W-1:0]          outWrIdx,
  output logic [IDX_W-1:0]          rdIdx,
  output logic signed [SHIFT_W-1:0] shiftCur
);

  logic [IDX_W:0] refCnt;
  logic [IDX_W:0] outCnt;
  logic           skipInit;
  logic           bothReady;

  assign bothReady  = (refCnt != '0) && (outCnt != '0);
  assign stb.wrRef  = tagValid && (tagSrc_e'(tagSrc) == SRC_REF);
  assign stb.wrOut  = tagValid && (tagSrc_e'(tagSrc) == SRC_OUT);
  assign stb.resync = !tagValid && bothReady && skipInit;
  assign stb.emit   = !tagValid && bothReady && !skipInit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt   <= '0;
      outCnt   <= '0;
      refWrIdx <= '0;
      outWrIdx <= '0;
      rdIdx    <= '0;
      skipInit <= 1'b1;
      shiftCur <= '0;
    end else if (stb.resync) begin
      refCnt   <= '0;
      outCnt   <= '0;
      refWrIdx <= '0;
      outWrIdx <= '0;
      rdIdx    <= '0;
      skipInit <= 1'b0;
    end else if (stb.emit) begin
      rdIdx  <= rdIdx + IDX_W'(1);
      refCnt <= refCnt - 1'b1;
      outCnt <= outCnt - 1'b1;
      if (locked) begin
        if (shiftCur < shiftTarget)      shiftCur <= shiftCur + SHIFT_W'(1);
        else if (shiftCur > shiftTarget) shiftCur <= shiftCur - SHIFT_W'(1);
      end
    end else begin
      if (stb.wrRef) begin
        refWrIdx <= refWrIdx + IDX_W'(1);
        refCnt   <= refCnt + 1'b1;
      end
      if (stb.wrOut) begin
        outWrIdx <= outWrIdx + IDX_W'(1);
        outCnt   <= outCnt + 1'b1;
      end
    end
  end

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt <= (IDX_W+1)'(DEPTH)) && (outCnt <= (IDX_W+1)'(DEPTH))); // R2
  AST_EMIT_CONSUMES: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |=> (refCnt == $past(refCnt) - 1'b1) && (outCnt == $past(outCnt) - 1'b1)); // R5
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.emit && locked) |=> $stable(shiftCur)); // R8
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && locked && (shiftCur < shiftTarget)) |=> (shiftCur > $past(shiftCur))); // R8

endmodule

// File: rtl/tpdDatapath.sv
module tpdDatapath
  import tpd_pkg::*;
#(
  parameter int TAG_BITS  = 22,
  parameter int DEPTH     = 64,
  parameter int SHIFT_W   = 16,
  parameter int ERR_W     = 24,
  parameter int ERR_CLAMP = 1000000,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int ADD_W    = TAG_BITS + 4,
  localparam int CALC_W   = ((ADD_W > SHIFT_W) ? ADD_W : SHIFT_W) + 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               stb,
  input  logic [IDX_W-1:0]          refWrIdx,
  input  logic [IDX_W-1:0]          outWrIdx,
  input  logic [IDX_W-1:0]          rdIdx,
  input  logic signed [SHIFT_W-1:0] shiftCur,
  input  logic [TAG_BITS-1:0]       tagValue,
  output logic                      errValid,
  output logic signed [ERR_W-1:0]   errValue
);

  localparam logic [ADD_W-1:0] REBASE_LIMIT = {{(ADD_W-TAG_BITS-3){1'b0}}, 1'b1, {(TAG_BITS+2){1'b0}}};
  localparam logic signed [CALC_W-1:0] CALC_HI = CALC_W'(ERR_CLAMP);
  localparam logic signed [CALC_W-1:0] CALC_LO = -CALC_HI;
  localparam logic signed [ERR_W-1:0]  OUT_HI  = ERR_W'(ERR_CLAMP);
  localparam logic signed [ERR_W-1:0]  OUT_LO  = -OUT_HI;

  logic                wrEnCh  [NUM_CH];
  logic [IDX_W-1:0]    wrIdxCh [NUM_CH];
  logic [TAG_BITS-1:0] rdTag   [NUM_CH];
  logic [ADD_W-1:0]    rdAdd   [NUM_CH];
  logic                rebase;

  assign wrEnCh[0]  = stb.wrRef;
  assign wrEnCh[1]  = stb.wrOut;
  assign wrIdxCh[0] = refWrIdx;
  assign wrIdxCh[1] = outWrIdx;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gHist
    tpdHistory #(
      .TAG_BITS(TAG_BITS),
      .ADD_W   (ADD_W),
      .DEPTH   (DEPTH)
    ) uHist (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (wrEnCh[ch]),
      .wrIdx  (wrIdxCh[ch]),
      .tagIn  (tagValue),
      .clrLast(stb.resync),
      .rebase (rebase),
      .rdIdx  (rdIdx),
      .rdTag  (rdTag[ch]),
      .rdAdder(rdAdd[ch])
    );
  end

  assign rebase = stb.emit && (rdAdd[0] > REBASE_LIMIT) && (rdAdd[1] > REBASE_LIMIT);

  logic [CALC_W-1:0]        refPhase;
  logic [CALC_W-1:0]        outPhase;
  logic signed [CALC_W-1:0] rawErr;
  logic signed [CALC_W-1:0] clipErr;

  assign refPhase = {{(CALC_W-ADD_W){1'b0}}, rdAdd[0]}
                  + {{(CALC_W-TAG_BITS){1'b0}}, rdTag[0]}
                  + {{(CALC_W-SHIFT_W){shiftCur[SHIFT_W-1]}}, shiftCur};
  assign outPhase = {{(CALC_W-ADD_W){1'b0}}, rdAdd[1]}
                  + {{(CALC_W-TAG_BITS){1'b0}}, rdTag[1]};
  assign rawErr   = signed'(refPhase - outPhase);

  always_comb begin
    if (rawErr > CALC_HI)      clipErr = CALC_HI;
    else if (rawErr < CALC_LO) clipErr = CALC_LO;
    else                       clipErr = rawErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errValue <= '0;
    end else begin
      errValid <= stb.emit;
      if (stb.emit) errValue <= clipErr[ERR_W-1:0];
    end
  end

  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> ((errValue <= OUT_HI) && (errValue >= OUT_LO))); // R6
  AST_RESYNC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stb.resync |=> !errValid); // R4

endmodule

// File: rtl/tagPhaseDetector.sv
module tagPhaseDetector
  import tpd_pkg::*;
#(
  parameter int TAG_BITS   = 22,
  parameter int HIST_DEPTH = 64,
  parameter int SHIFT_W    = 16,
  parameter int ERR_W      = 24,
  parameter int ERR_CLAMP  = 1000000,
  localparam int IDX_W     = $clog2(HIST_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tagValid,
  input  logic                      tagSrc,
  input  logic [TAG_BITS-1:0]       tagValue,
  input  logic                      locked,
  input  logic signed [SHIFT_W-1:0] shiftTarget,
  output logic                      errValid,
  output logic signed [ERR_W-1:0]   errValue
);

  ctrlStrobe_t               stb;
  logic [IDX_W-1:0]          refWrIdx;
  logic [IDX_W-1:0]          outWrIdx;
  logic [IDX_W-1:0]          rdIdx;
  logic signed [SHIFT_W-1:0] shiftCur;

  tpdControl #(
    .DEPTH  (HIST_DEPTH),
    .SHIFT_W(SHIFT_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tagValid   (tagValid),
    .tagSrc     (tagSrc),
    .locked     (locked),
    .shiftTarget(shiftTarget),
    .stb        (stb),
    .refWrIdx   (refWrIdx),
    .outWrIdx   (outWrIdx),
    .rdIdx      (rdIdx),
    .shiftCur   (shiftCur)
  );

  tpdDatapath #(
    .TAG_BITS (TAG_BITS),
    .DEPTH    (HIST_DEPTH),
    .SHIFT_W  (SHIFT_W),
    .ERR_W    (ERR_W),
    .ERR_CLAMP(ERR_CLAMP)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .refWrIdx(refWrIdx),
    .outWrIdx(outWrIdx),
    .rdIdx   (rdIdx),
    .shiftCur(shiftCur),
    .tagValue(tagValue),
    .errValid(errValid),
    .errValue(errValue)
  );

  AST_TAG_DEFERS: assert property (@(posedge clk) disable iff (!rstN)
    tagValid |=> !errValid); // R9

endmodule

// File: tb/sim_tagPhaseDetector.sv
module sim_tagPhaseDetector;

  localparam int TB = 22;
  localparam int EW = 24;
  localparam int SW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rstN;
  logic                 tagValid;
  logic                 tagSrc;
  logic [TB-1:0]        tagValue;
  logic                 locked;
  logic signed [SW-1:0] shiftTarget;
  logic                 errValid;
  logic signed [EW-1:0] errValue;

  tagPhaseDetector u0 (
    .clk(clk), .rstN(rstN), .tagValid(tagValid), .tagSrc(tagSrc),
    .tagValue(tagValue), .locked(locked), .shiftTarget(shiftTarget),
    .errValid(errValid), .errValue(errValue)
  );

  // {refTag, outTag, expected error}
  localparam int NVEC = 7;
  localparam logic [2*TB+EW-1:0] VEC [NVEC] = '{
    {22'd1000,    22'd900,     24'sd100},      // R5 plain
    {22'd5000,    22'd5200,    -24'sd200},     // R5 negative
    {22'd4194000, 22'd4193000, 24'sd1000},     // R5 near top
    {22'd300,     22'd4194200, 24'sd404},      // R3 ref wraps only
    {22'd600,     22'd100,     24'sd500},      // R3 out wraps
    {22'd2000000, 22'd100,     24'sd1000000},  // R6 high clamp, R3 equal tag
    {22'd2000100, 22'd3500000, -24'sd1000000}  // R6 low clamp
  };

  int nRun = 0;
  int nFail = 0;
  int capN = 0;
  logic signed [EW-1:0] capErr [0:511];

  always begin
    @(posedge clk);
    #5;
    if (rstN && errValid) begin
      if (capN < 512) capErr[capN] = errValue;
      capN++;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendTag(input logic src, input int v);
    tagValid = 1'b1;
    tagSrc   = src;
    tagValue = v[TB-1:0];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    tagValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pairCheck(input string req, input int r, input int o, input longint exp);
    int base;
    base = capN;
    sendTag(1'b0, r);
    sendTag(1'b1, o);
    idle(3);
    check(req, capN - base, 1);
    check(req, capErr[base], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int base;
    rstN = 1'b0; tagValid = 1'b0; tagSrc = 1'b0; tagValue = '0;
    locked = 1'b0; shiftTarget = '0;
    repeat (3) @(negedge clk);
    check("R1 errValid in reset", errValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 errValid after reset", errValid, 0);

    // R2: reference alone gives nothing
    sendTag(1'b0, 100);
    idle(4);
    check("R2 no error with one side empty", capN, 0);
    // R4: first pairing is discarded
    sendTag(1'b1, 200);
    idle(4);
    check("R4 skip-first emits nothing", capN, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      pairCheck("R5/R3/R6 vector", int'(VEC[i][2*TB+EW-1:TB+EW]), int'(VEC[i][TB+EW-1:EW]),
                longint'($signed(VEC[i][EW-1:0])));
    end

    // R5 ordering, R9 deferral under back-to-back tags
    base = capN;
    sendTag(1'b0, 3600000);
    sendTag(1'b0, 3700000);
    idle(3);
    check("R2 refs pending without outs", capN - base, 0);
    sendTag(1'b1, 3599990);
    sendTag(1'b1, 3699950);
    idle(4);
    check("R9 both deferred errors arrive", capN - base, 2);
    check("R5 first pair in order", capErr[base], 10);
    check("R5 second pair in order", capErr[base + 1], 50);

    // R7 rebase: many wraps on both channels
    for (int k = 0; k < 20; k++) begin
      pairCheck("R7 rebase trio a", 4194000, 4193990, 10);
      pairCheck("R7 rebase trio b", 50, 4194100, 254);
      pairCheck("R7 rebase trio c", 500, 400, 100);
    end

    // R8 shift slewing
    locked = 1'b1;
    shiftTarget = 16'sd3;
    for (int i = 0; i < 5; i++)
      pairCheck("R8 slew up", 1000 + 10*i, 1000 + 10*i, (i < 3) ? i : 3);
    shiftTarget = -16'sd1;
    for (int i = 0; i < 5; i++)
      pairCheck("R8 slew down", 1100 + 10*i, 1100 + 10*i, 3 - i);
    locked = 1'b0;
    shiftTarget = 16'sd5;
    for (int i = 0; i < 2; i++)
      pairCheck("R8 hold when unlocked", 1200 + 10*i, 1200 + 10*i, -1);

    // R1/R4 after a second reset: shift cleared, skip-first again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    base = capN;
    sendTag(1'b0, 50);
    sendTag(1'b1, 60);
    idle(4);
    check("R4 skip-first after reset", capN - base, 0);
    pairCheck("R1 shift cleared by reset", 70, 65, 5);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule